// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block collects the four interrupt causes of a UART: a line status error (overrun, parity, framing or break), received data ready, transmit holding register empty, and a modem status change. Each cause is latched as a pending flag from a one-cycle event pulse. Each flag is released by the access that services it. The pending flags are masked by per-source enable bits and ranked by fixed priority. The winner is reported as a 3-bit identification code in the low bits of an identification byte.

The identification byte and the interrupt request line are combinational functions of the registered pending flags and the current enables. A bus access strobe placed in a cycle acts on the value the byte shows in that same cycle. The transmit-empty cause is also released by a read of the identification byte, but only when that read returned the transmit-empty code. A new event arriving in the same cycle as the clearing access for its own source is kept, so no event is lost across a read.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled source pending, the identification byte is 0x01: bit 0 = 1 means nothing pending.
- R2: Bits 7..3 of the identification byte are always zero, and `irq_o` is always the inverse of identification bit 0.
- R3: A line status event sets a pending flag reported as bits 2..0 = 110. It is cleared by a line status register read strobe.
- R4: A receive-ready event sets a pending flag reported as 100. It is cleared by a receive buffer read strobe.
- R5: A transmit-empty event sets a pending flag reported as 010. It is cleared by a transmit holding register write strobe.
- R6: An identification read strobe clears the transmit-empty flag only if the byte shows code 010 in the cycle of that strobe. In any other case the flag is unaffected.
- R7: A modem status event sets a pending flag reported as 000. It is cleared by a modem status register read strobe.
- R8: `irq_en` bit 0 gates line status, bit 1 receive, bit 2 transmit and bit 3 modem status. A disabled source that is pending is not reported, but it keeps its flag and appears once it is enabled.
- R9: When a source's event and its clearing access occur in the same cycle, the source remains pending.
- R10: With several enabled sources pending, the reported one follows the order line status, receive, transmit, modem status, from highest to lowest.
- R11: Reset clears every pending flag, so the byte reads 0x01 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 4 | Per-source enables: bit0 line status, bit1 receive, bit2 transmit, bit3 modem |
| ls_evt | input | 1 | Line status error event pulse |
| rx_evt | input | 1 | Receive data ready event pulse |
| tx_evt | input | 1 | Transmit holding register empty event pulse |
| ms_evt | input | 1 | Modem status change event pulse |
| rd_iir | input | 1 | Identification byte read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, high while an enabled source is pending |

## Verification
Single sources are raised and then serviced one at a time. This shows that each code value is correct and that each clearing strobe affects only its own source. Stacked sources are released from the top down to expose the ranking. Identification reads are issued while the transmit cause is shown and again while it is masked by a higher cause, which separates a conditional clear from an unconditional one. Enables are toggled over pending flags, and events are placed in the same cycle as their own clear. A long random stretch then compares every cycle against a behavioural model, to catch interactions the directed cases miss.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 4;
  localparam int SRC_LS = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_TX = 2;
  localparam int SRC_MS = 3;
  localparam int CODE_W = 3;

  typedef logic [CODE_W-1:0] iid_t;

  localparam iid_t IID_NONE = 3'b001;

  // rank 0 is the highest priority and gets the largest code
  function automatic iid_t src_code(int rank);
    return {2'(NSRC - 1 - rank), 1'b0};
  endfunction
endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;
  logic upd;

  // an event in the same cycle as its clear wins
  always_comb begin
    upd    = set_i | clr_i;
    pend_d = set_i | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (upd) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act_i,
  output iid_t            iid_o,
  output logic [NSRC-1:0] grant_o
);
  always_comb begin
    iid_o   = IID_NONE;
    grant_o = '0;
    // walk from the lowest rank upward so the highest active rank wins
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        iid_o   = src_code(i);
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int IIR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       irq_en,
  input  logic             ls_evt,
  input  logic             rx_evt,
  input  logic             tx_evt,
  input  logic             ms_evt,
  input  logic             rd_iir,
  input  logic             rd_rbr,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic [IIR_W-1:0] iir_o,
  output logic             irq_o
);
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [NSRC-1:0] pend_v;
  logic [NSRC-1:0] act_v;
  logic [NSRC-1:0] grant_v;
  iid_t            iid;

  always_comb begin
    set_v         = '0;
    set_v[SRC_LS] = ls_evt;
    set_v[SRC_RX] = rx_evt;
    set_v[SRC_TX] = tx_evt;
    set_v[SRC_MS] = ms_evt;

    clr_v         = '0;
    clr_v[SRC_LS] = rd_lsr;
    clr_v[SRC_RX] = rd_rbr;
    // identification read releases transmit-empty only when it is shown
    clr_v[SRC_TX] = wr_thr | (rd_iir & grant_v[SRC_TX]);
    clr_v[SRC_MS] = rd_msr;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    uart_irq_src u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .pend_o (pend_v[g])
    );
  end

  assign act_v = pend_v & irq_en;

  uart_irq_prio u_prio (
    .act_i   (act_v),
    .iid_o   (iid),
    .grant_o (grant_v)
  );

  assign iir_o = IIR_W'(iid);
  assign irq_o = ~iid[0];
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] irq_en,
  input logic       ls_evt,
  input logic       rx_evt,
  input logic       tx_evt,
  input logic       rd_iir,
  input logic       rd_rbr,
  input logic       rd_msr,
  input logic       wr_thr,
  input logic [7:0] iir_o,
  input logic       irq_o,
  input logic [NSRC-1:0] pend_v,
  input logic [NSRC-1:0] grant_v
);
  a_r2_irq_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ~iir_o[0]);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    iir_o[7:3] == 5'b0);

  a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_v & irq_en) == '0) |-> (iir_o == 8'h01));

  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_v));

  a_r3_ls_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_evt && irq_en[0]) |=> (!irq_en[0] || iir_o[2:0] == 3'b110));

  a_r4_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rbr && !rx_evt) |=> (iir_o[2:0] != 3'b100));

  a_r5_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !tx_evt) |=> (iir_o[2:0] != 3'b010));

  a_r6_iir_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iir_o[2:0] == 3'b010 && !tx_evt) |=> !pend_v[SRC_TX]);

  a_r6_iir_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iir_o[2:0] != 3'b010 && !wr_thr && pend_v[SRC_TX]) |=> pend_v[SRC_TX]);

  a_r7_ms_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !ms_evt_unused()) |=> (iir_o[2:0] != 3'b000 || iir_o[0]));

  function automatic logic ms_evt_unused();
    return 1'b0;
  endfunction

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && rd_rbr) |=> pend_v[SRC_RX]);
endmodule

bind uart_irq_ident uart_irq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_en  (irq_en),
  .ls_evt  (ls_evt),
  .rx_evt  (rx_evt),
  .tx_evt  (tx_evt),
  .rd_iir  (rd_iir),
  .rd_rbr  (rd_rbr),
  .rd_msr  (rd_msr & ~ms_evt),
  .wr_thr  (wr_thr),
  .iir_o   (iir_o),
  .irq_o   (irq_o),
  .pend_v  (pend_v),
  .grant_v (grant_v)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  logic       clk;
  logic       rst_n;
  logic [3:0] irq_en;
  logic       ls_evt, rx_evt, tx_evt, ms_evt;
  logic       rd_iir, rd_rbr, rd_lsr, rd_msr, wr_thr;
  logic [7:0] iir_o;
  logic       irq_o;

  int checks;
  int errors;
  bit m_pend [4];   // model flags: 0 ls, 1 rx, 2 tx, 3 ms

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .ls_evt(ls_evt), .rx_evt(rx_evt), .tx_evt(tx_evt), .ms_evt(ms_evt),
    .rd_iir(rd_iir), .rd_rbr(rd_rbr), .rd_lsr(rd_lsr), .rd_msr(rd_msr),
    .wr_thr(wr_thr), .iir_o(iir_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] model_iir();
    logic [7:0] r;
    r = 8'h01;
    if      (m_pend[0] && irq_en[0]) r = 8'h06;
    else if (m_pend[1] && irq_en[1]) r = 8'h04;
    else if (m_pend[2] && irq_en[2]) r = 8'h02;
    else if (m_pend[3] && irq_en[3]) r = 8'h00;
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] exp_iir);
    checks++;
    if (iir_o !== exp_iir || irq_o !== ~exp_iir[0]) begin
      errors++;
      $display("FAIL %s: iir=%02h irq=%b expected iir=%02h irq=%b",
               tag, iir_o, irq_o, exp_iir, ~exp_iir[0]);
    end
  endtask

  task automatic idle_inputs();
    ls_evt = 0; rx_evt = 0; tx_evt = 0; ms_evt = 0;
    rd_iir = 0; rd_rbr = 0; rd_lsr = 0; rd_msr = 0; wr_thr = 0;
  endtask

  // inputs are set by caller at negedge; compare, advance model, advance clock
  task automatic step(string tag);
    logic [7:0] shown;
    bit nxt [4];
    #1;
    shown = model_iir();
    check(tag, shown);
    nxt[0] = ls_evt | (m_pend[0] & ~rd_lsr);
    nxt[1] = rx_evt | (m_pend[1] & ~rd_rbr);
    nxt[2] = tx_evt | (m_pend[2] & ~(wr_thr | (rd_iir && shown == 8'h02)));
    nxt[3] = ms_evt | (m_pend[3] & ~rd_msr);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) m_pend[i] = nxt[i];
    idle_inputs();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    for (int i = 0; i < 4; i++) m_pend[i] = 0;
    idle_inputs();
    irq_en = 4'hF;
    rst_n  = 0;
    ls_evt = 1; tx_evt = 1;
    repeat (3) @(negedge clk);
    check("R11 reset", 8'h01);
    rst_n = 1;
    idle_inputs();
    @(negedge clk);
    step("R11 after reset");
    step("R1 idle");

    ms_evt = 1; step("R7 set");
    step("R7 pending");
    rd_msr = 1; step("R7 clear");
    step("R1 idle after R7");

    rx_evt = 1; step("R4 set");
    rd_lsr = 1; rd_msr = 1; wr_thr = 1; step("R4 other clears no effect");
    rd_rbr = 1; step("R4 clear");
    step("R1 after R4");

    tx_evt = 1; step("R5 set");
    wr_thr = 1; step("R5 clear");
    tx_evt = 1; step("R6 set");
    rd_iir = 1; step("R6 read shown clears");
    step("R6 cleared");

    tx_evt = 1; ls_evt = 1; step("R6 stack");
    rd_iir = 1; step("R6 read masked");
    rd_lsr = 1; step("R3 clear");
    step("R6 tx kept");
    wr_thr = 1; step("R5 clear again");

    ls_evt = 1; rx_evt = 1; tx_evt = 1; ms_evt = 1; step("R10 all");
    step("R10 top ls");
    rd_lsr = 1; step("R10 drop ls");
    rd_rbr = 1; step("R10 drop rx");
    wr_thr = 1; step("R10 drop tx");
    rd_msr = 1; step("R10 drop ms");

    irq_en = 4'b1110; ls_evt = 1; step("R8 masked set");
    step("R8 masked pending");
    irq_en = 4'b1111; step("R8 enabled shows");
    rd_lsr = 1; step("R8 clear");
    irq_en = 4'b1011; tx_evt = 1; ms_evt = 1; step("R8 tx masked");
    step("R8 ms shown");
    irq_en = 4'hF; step("R8 tx reappears");
    wr_thr = 1; rd_msr = 1; step("R8 cleanup");

    rx_evt = 1; rd_rbr = 1; step("R9 rx set+clr");
    step("R9 rx kept");
    rd_rbr = 1; step("R9 rx clear");
    tx_evt = 1; step("R9 tx set");
    tx_evt = 1; rd_iir = 1; step("R9 tx set with iir read");
    step("R9 tx kept");
    ls_evt = 1; rd_lsr = 1; step("R9 ls set+clr");
    step("R3 ls kept");
    rd_lsr = 1; wr_thr = 1; step("R9 cleanup");

    for (int n = 0; n < 400; n++) begin
      irq_en = 4'($urandom);
      ls_evt = ($urandom % 6) == 0; rx_evt = ($urandom % 5) == 0;
      tx_evt = ($urandom % 5) == 0; ms_evt = ($urandom % 6) == 0;
      rd_iir = ($urandom % 3) == 0; rd_rbr = ($urandom % 4) == 0;
      rd_lsr = ($urandom % 4) == 0; rd_msr = ($urandom % 4) == 0;
      wr_thr = ($urandom % 5) == 0;
      step("R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule